// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the card bus clock from the reference clock. The division has two stages: a prescaler that takes only zero or a power of two, followed by a small divider of the form N+1. Software writes a 16-bit rate word and issues start, stop and soft-reset commands through a 4-bit control write. The block drives the card clock as a registered signal. It also drives a one-cycle enable strobe at the start of each card clock period, for logic that runs in the reference domain, and a status flag that tells whether the card clock is running.

A small state machine owns the output. Its states are:

- `ST_IDLE`: stopped, output low.
- `ST_RUN`: producing periods.
- `ST_DRAIN`: a stop is pending and the current period is being finished.
- `ST_RESET`: soft reset in progress. The state lasts a fixed number of cycles.

Its transitions are:

- start: `ST_IDLE`→`ST_RUN`.
- stop-request: `ST_RUN`→`ST_DRAIN`.
- cancel: `ST_DRAIN`→`ST_RUN`, taken on a start.
- period-end with a pending stop: `ST_RUN`/`ST_DRAIN`→`ST_IDLE`.
- period-end without a pending stop: `ST_RUN`/`ST_DRAIN`→`ST_RUN`, which reloads the ratio.
- soft-reset: any state except `ST_RESET`→`ST_RESET`.
- reset-done: `ST_RESET`→`ST_IDLE`.

Start and stop therefore only act at a moment when the card clock is low, so no shortened pulse can appear. A new rate is picked up only at a period boundary.

Top module: `sdcard_clk_gen`

## Requirements
- R1: The rate word holds the divider D in bits [3:0] and the prescaler P in bits [15:4]. The division ratio is N = D+1 when P is 0, and N = (D+1)·2·P otherwise. This gives a ratio range of 2 to 65536.
- R2: A divider value D of 0 is treated as 1.
- R3: A prescaler value P that is not zero and not a power of two is treated as its highest set bit. For example, 0x03 acts as 2 and 0xC0 acts as 0x80.
- R4: Each period of the card clock is high for floor(N/2) reference cycles and then low for ceil(N/2) cycles. The duty cycle is therefore 50 % for every even N.
- R5: A control write with bit 1 (start) set while the clock is stopped makes the card clock high, and the running flag high, in the cycle after the write.
- R6: A control write with bit 0 (stop) set while the clock runs lets the current period complete. The running flag falls and the output stays low from the first cycle after that period's low phase. This also holds when the stop arrives in the last cycle of a period.
- R7: When start and stop are set in the same write, stop wins. A start written while a stop is pending cancels the stop.
- R8: A rate write while the clock runs does not alter the current period. It takes effect from the next period.
- R9: A control write with bit 3 (soft reset) set takes priority over start and stop. The output and the running flag are low from the next cycle, and the rate word returns to 0x0013 (N = 8). The block then stays in reset for RST_CYCLES (8) cycles, during which control writes and rate writes are ignored.
- R10: `card_clk_en` is high for exactly one cycle, the first high cycle of each card clock period. It is never high while the clock is stopped.
- R11: After the hardware reset the clock is stopped, the output is low and the rate word is 0x0013.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_wr | input | 1 | Rate word write strobe |
| rate_wdata | input | 16 | Rate word: [3:0] divider, [15:4] prescaler |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Control bits: 0 stop, 1 start, 3 soft reset, 2 unused |
| card_clk | output | 1 | Card bus clock (registered) |
| card_clk_en | output | 1 | One-cycle strobe at the start of each card clock period |
| clk_running | output | 1 | High while the card clock is running |

## Verification
The collision that matters is a stop request landing in the same cycle as the period-end. In that case the block must go straight to idle rather than begin another high phase. A stop and a start in one control write is the other collision, where stop must prevail. The bench provokes the first case by sweeping the delay between start and stop across every phase of a 5-cycle period, and the second with combined control writes in idle, running and draining states. A behavioural model that tracks phase and ratio with integers is compared against the clock, the strobe and the running flag on every cycle. Separate measurements of the strobe spacing then judge each ratio, including the clamped settings.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_RESET = 2'd3
    } gen_state_t;

    localparam int CTRL_STOP_BIT  = 0;
    localparam int CTRL_START_BIT = 1;
    localparam int CTRL_SRST_BIT  = 3;
endpackage

// File: rtl/sdclk_rate_decode.sv
module sdclk_rate_decode #(
    parameter int DIV_W = 4,
    parameter int PRE_W = 12,
    localparam int NW   = DIV_W + 1 + PRE_W,
    localparam int SW   = $clog2(PRE_W + 1)
) (
    input  logic [DIV_W+PRE_W-1:0] rate,
    output logic [NW-1:0]          ratio
);
    logic [DIV_W-1:0] div_c;
    logic [PRE_W-1:0] pre;
    logic [SW-1:0]    shift;
    logic [NW-1:0]    base;

    always_comb begin
        // R2: a zero divider acts as one
        div_c = rate[DIV_W-1:0];
        if (div_c == '0) div_c = DIV_W'(1);
        // R3: keep only the highest set prescaler bit; power 2^k doubles to shift k+1
        pre   = rate[DIV_W+PRE_W-1:DIV_W];
        shift = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (pre[i]) shift = SW'(i + 1);
        end
        base  = {{(NW-DIV_W){1'b0}}, div_c} + NW'(1);
        ratio = base << shift;
    end
endmodule

// File: rtl/sdclk_phase_counter.sv
module sdclk_phase_counter #(
    parameter int NW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic          advance,
    input  logic [NW-1:0] ratio_new,
    output logic          period_end,
    output logic          at_zero,
    output logic          card_clk
);
    logic [NW-1:0] cnt;
    logic [NW-1:0] act_n;
    logic [NW-1:0] cnt_inc;

    assign cnt_inc    = cnt + NW'(1);
    assign period_end = (cnt == act_n - NW'(1));
    assign at_zero    = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_n    <= NW'(2);
            card_clk <= 1'b0;
        end else if (clear) begin
            cnt      <= '0;
            card_clk <= 1'b0;
        end else if (load) begin
            cnt      <= '0;
            act_n    <= ratio_new;
            card_clk <= 1'b1;
        end else if (advance) begin
            cnt      <= cnt_inc;
            card_clk <= (cnt_inc < (act_n >> 1));
        end
    end

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < act_n);
    p_load_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> card_clk);
    p_clear_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !card_clk);
endmodule

// File: rtl/sdclk_ctrl_fsm.sv
module sdclk_ctrl_fsm
    import sdclk_pkg::*;
#(
    parameter int RST_CYCLES = 8,
    localparam int RCW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic start_req,
    input  logic stop_req,
    input  logic period_end,
    output logic clear,
    output logic load,
    output logic advance,
    output logic running,
    output logic in_reset
);
    gen_state_t st, st_nx;
    logic [RCW-1:0] rcnt, rcnt_nx;
    logic go, pend;

    always_comb begin
        st_nx   = st;
        rcnt_nx = rcnt;
        clear   = 1'b0;
        load    = 1'b0;
        advance = 1'b0;
        go      = start_req && !stop_req;                  // R7: stop wins
        pend    = stop_req || ((st == ST_DRAIN) && !go);   // R7: start cancels
        unique case (st)
            ST_IDLE: begin
                if (soft_rst) begin
                    st_nx = ST_RESET; clear = 1'b1; rcnt_nx = '0;
                end else if (go) begin
                    st_nx = ST_RUN; load = 1'b1;
                end else begin
                    clear = 1'b1;
                end
            end
            ST_RUN, ST_DRAIN: begin
                if (soft_rst) begin
                    st_nx = ST_RESET; clear = 1'b1; rcnt_nx = '0;
                end else if (period_end) begin
                    if (pend) begin
                        st_nx = ST_IDLE; clear = 1'b1;
                    end else begin
                        st_nx = ST_RUN; load = 1'b1;
                    end
                end else begin
                    advance = 1'b1;
                    st_nx   = pend ? ST_DRAIN : ST_RUN;
                end
            end
            ST_RESET: begin
                clear = 1'b1;
                if (rcnt == RCW'(RST_CYCLES - 1)) st_nx = ST_IDLE;
                else rcnt_nx = rcnt + RCW'(1);
            end
            default: begin
                st_nx = ST_IDLE; clear = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            rcnt <= '0;
        end else begin
            st   <= st_nx;
            rcnt <= rcnt_nx;
        end
    end

    always_comb begin
        running  = (st == ST_RUN) || (st == ST_DRAIN);
        in_reset = (st == ST_RESET);
    end

    p_reset_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESET && rcnt != RCW'(RST_CYCLES - 1)) |=> (st == ST_RESET));
    p_reset_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESET && rcnt == RCW'(RST_CYCLES - 1)) |=> (st == ST_IDLE));
endmodule

// File: rtl/sdcard_clk_gen.sv
module sdcard_clk_gen
    import sdclk_pkg::*;
#(
    parameter int          DIV_W      = 4,
    parameter int          PRE_W      = 12,
    parameter int          RST_CYCLES = 8,
    parameter logic [15:0] RATE_INIT  = 16'h0013,
    localparam int         RW         = DIV_W + PRE_W,
    localparam int         NW         = DIV_W + 1 + PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rate_wr,
    input  logic [RW-1:0] rate_wdata,
    input  logic          ctrl_wr,
    input  logic [3:0]    ctrl_wdata,
    output logic          card_clk,
    output logic          card_clk_en,
    output logic          clk_running
);
    logic [RW-1:0] rate_q;
    logic [NW-1:0] ratio;
    logic soft_rst, start_req, stop_req;
    logic clear, load, advance, in_reset, period_end, at_zero;
    logic unused_ctrl_bit;

    assign unused_ctrl_bit = ctrl_wdata[2];
    assign soft_rst  = ctrl_wr && ctrl_wdata[CTRL_SRST_BIT];
    assign start_req = ctrl_wr && ctrl_wdata[CTRL_START_BIT];
    assign stop_req  = ctrl_wr && ctrl_wdata[CTRL_STOP_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     rate_q <= RW'(RATE_INIT);
        else if (soft_rst && !in_reset) rate_q <= RW'(RATE_INIT);
        else if (rate_wr && !in_reset)  rate_q <= rate_wdata;
    end

    sdclk_rate_decode #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_decode (
        .rate  (rate_q),
        .ratio (ratio)
    );

    sdclk_ctrl_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .period_end (period_end),
        .clear      (clear),
        .load       (load),
        .advance    (advance),
        .running    (clk_running),
        .in_reset   (in_reset)
    );

    sdclk_phase_counter #(.NW(NW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .load       (load),
        .advance    (advance),
        .ratio_new  (ratio),
        .period_end (period_end),
        .at_zero    (at_zero),
        .card_clk   (card_clk)
    );

    assign card_clk_en = clk_running && at_zero;

    p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_running |-> !card_clk);
    p_en_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk_en |-> card_clk);
    p_start_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_running) |-> card_clk);
    p_stop_glitchfree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_running) && !in_reset) |-> !$past(card_clk));
    p_reset_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset |=> !clk_running);
endmodule

// File: tb/test_sdcard_clk_gen.sv
`timescale 1ns/1ps
module test_sdcard_clk_gen;
    localparam int RST_CYC = 8;
    localparam int INIT    = 16'h0013;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_wr = 1'b0;
    logic [15:0] rate_wdata = '0;
    logic        ctrl_wr = 1'b0;
    logic [3:0]  ctrl_wdata = '0;
    logic        card_clk, card_clk_en, clk_running;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R11";

    sdcard_clk_gen i_sdcard_clk_gen (
        .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .card_clk(card_clk),
        .card_clk_en(card_clk_en), .clk_running(clk_running)
    );

    always #4 clk = ~clk;

    // behavioural reference
    int m_rate = INIT, m_n = 2, m_ph = 0, m_rl = 0;
    bit m_run = 0, m_pend = 0;

    function automatic int n_of(int r);
        int d, p, pp;
        d = r % 16;
        if (d == 0) d = 1;
        p = r / 16;
        if (p == 0) return d + 1;
        pp = 1;
        while (pp * 2 <= p) pp = pp * 2;
        return (d + 1) * 2 * pp;
    endfunction

    always @(posedge clk) begin
        bit sr, sa, sp, go, pend;
        sr = ctrl_wr && ctrl_wdata[3];
        sa = ctrl_wr && ctrl_wdata[1];
        sp = ctrl_wr && ctrl_wdata[0];
        go = sa && !sp;
        cycles++;
        if (!rst_n) begin
            m_rate = INIT; m_run = 0; m_pend = 0; m_ph = 0; m_n = 2; m_rl = 0;
        end else if (m_rl > 0) begin
            m_rl--;
        end else if (sr) begin
            m_run = 0; m_pend = 0; m_ph = 0; m_rate = INIT; m_rl = RST_CYC;
        end else begin
            if (!m_run) begin
                if (go) begin m_run = 1; m_pend = 0; m_ph = 0; m_n = n_of(m_rate); end
            end else begin
                pend = sp || (m_pend && !go);
                if (m_ph == m_n - 1) begin
                    if (pend) begin m_run = 0; m_ph = 0; m_pend = 0; end
                    else begin m_ph = 0; m_n = n_of(m_rate); m_pend = 0; end
                end else begin
                    m_ph++; m_pend = pend;
                end
            end
            if (rate_wr) m_rate = rate_wdata;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (cycles > 1) begin
            bit e_clk, e_en;
            e_clk = m_run && (m_ph < m_n / 2);
            e_en  = m_run && (m_ph == 0);
            chk(card_clk == e_clk, cur_req, "card_clk", int'(card_clk), int'(e_clk));
            chk(card_clk_en == e_en, cur_req, "card_clk_en", int'(card_clk_en), int'(e_en));
            chk(clk_running == m_run, cur_req, "clk_running", int'(clk_running), int'(m_run));
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctrl(logic [3:0] b);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = b;
        @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic wrate(logic [15:0] v);
        @(negedge clk); rate_wr = 1'b1; rate_wdata = v;
        @(negedge clk); rate_wr = 1'b0;
    endtask

    task automatic wait_en();
        @(negedge clk);
        while (!card_clk_en) @(negedge clk);
    endtask

    task automatic measure(int exp, string req);
        int c;
        wait_en();
        wait_en();
        c = 0;
        do begin @(negedge clk); c++; end while (!card_clk_en);
        chk(c == exp, req, "strobe spacing", c, exp);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(5);
        chk(!clk_running && !card_clk, "R11", "stopped after reset", int'(clk_running), 0);

        cur_req = "R5";  ctrl(4'b0010); cyc(3);
        cur_req = "R4";  measure(8, "R1"); cyc(20);
        cur_req = "R8";  wrate(16'h0001); measure(2, "R8");
        cur_req = "R4";  wrate(16'h0002); measure(3, "R4"); cyc(10);
        cur_req = "R2";  wrate(16'h0010); measure(4, "R2");
        cur_req = "R3";  wrate(16'h0035); measure(24, "R3");
        wrate(16'h0C0F); measure(4096, "R3");
        cur_req = "R10"; wrate(16'h0004); measure(5, "R10"); cyc(12);

        cur_req = "R6";
        ctrl(4'b0001); cyc(15);
        chk(!clk_running, "R6", "stopped after stop", int'(clk_running), 0);
        for (int off = 0; off < 7; off++) begin
            ctrl(4'b0010); cyc(off); ctrl(4'b0001); cyc(12);
        end

        cur_req = "R7";
        ctrl(4'b0011); cyc(5);
        chk(!clk_running, "R7", "start+stop in idle", int'(clk_running), 0);
        ctrl(4'b0010); cyc(2); ctrl(4'b0011); cyc(12);
        chk(!clk_running, "R7", "start+stop while running", int'(clk_running), 0);
        ctrl(4'b0010); cyc(3); ctrl(4'b0001); ctrl(4'b0010); cyc(15);
        chk(clk_running, "R7", "start cancels pending stop", int'(clk_running), 1);

        cur_req = "R9";
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 4'b1000; rate_wr = 1'b1; rate_wdata = 16'h0001;
        @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = '0; rate_wr = 1'b0;
        chk(!clk_running && !card_clk, "R9", "soft reset stops at once", int'(card_clk), 0);
        ctrl(4'b0010); wrate(16'h0001); cyc(10);
        chk(!clk_running, "R9", "start ignored in reset", int'(clk_running), 0);
        ctrl(4'b0010); measure(8, "R9");
        ctrl(4'b1010); cyc(12);
        chk(!clk_running, "R9", "soft reset beats start", int'(clk_running), 0);
        ctrl(4'b0010); cyc(20);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule